// File: doc/BRIEF.md
# Clock-Domain Word Transfer with Four-Phase Handshake

This block carries one data word at a time from a source clock domain into an unrelated destination clock domain. The source asks for a transfer with a one-cycle send strobe. The word is copied into a register owned by the source, and a request level is raised. The source then reports itself busy until the whole exchange has closed.

The destination brings the request level across through a chain of synchronizer flops. On the first cycle it sees the request high, it copies the held word into its output register, raises a one-cycle valid pulse, and answers with an acknowledge level. That acknowledge crosses back through its own synchronizer. Seeing it high, the source drops the request. The destination then drops the acknowledge, and once the source sees the acknowledge low again it returns to idle.

Every step is a held level rather than a pulse, so any ratio between the two clocks is tolerated. The price is that a single transfer costs four synchronizer delays. Each domain has its own active-low reset. The data width and the synchronizer depth are parameters.

Top module: `handshake_xfer`

## Requirements
- R1: While the resets are held, srcBusy, dstValid and dstData (all bits) are 0.
- R2: A send strobe sampled high at a source clock edge while srcBusy is low accepts sendData. srcBusy is high from that edge on. srcBusy never rises at an edge where no send was sampled.
- R3: A send strobe sampled while srcBusy is high is ignored. No extra word is delivered, and the word already in flight is not altered by the new sendData.
- R4: Every accepted word appears on dstData exactly once, in the order accepted and unmodified, for destination clocks faster than, equal to and slower than the source clock.
- R5: dstValid is high for exactly one destination cycle per delivered word. dstData changes only in a cycle where dstValid is high and holds its value otherwise.
- R6: The request falls only after the synchronized acknowledge has been seen high. srcBusy falls only after the synchronized acknowledge is low again, which means the destination has already delivered the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low, asynchronous assert |
| sendStrobe | input | 1 | Request to transfer sendData, sampled on srcClk |
| sendData | input | DATA_W | Word to transfer |
| srcBusy | output | 1 | High from an accepted send until the handshake has closed |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain reset, active low, asynchronous assert |
| dstData | output | DATA_W | Last delivered word |
| dstValid | output | 1 | One-cycle pulse when dstData takes a new word |

## Verification
The two source-side events that can share a cycle are the controller going back to idle and a new send strobe. If a send lands on the last busy cycle, it must be dropped. If it lands on the first idle cycle, it must be taken. The bench provokes this by holding sendStrobe high for long stretches while sendData changes every cycle, so that a send attempt sits on every cycle around each busy edge. The reference model accepts a word only where it sampled srcBusy low, and every delivery is then checked against the model's queue. An attempt taken one cycle early or late therefore shows up as a wrong or unexpected word.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  // Source-side handshake phases
  typedef enum logic [1:0] {
    SRC_IDLE         = 2'd0,
    SRC_WAIT_ACK     = 2'd1,
    SRC_WAIT_ACK_LOW = 2'd2
  } srcState_t;

  // Strobes from control to datapath.
  // srcLoad is in the srcClk domain, dstCapture in the dstClk domain.
  typedef struct packed {
    logic srcLoad;
    logic dstCapture;
  } hsxStrobe_t;

endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hsx_ctrl.sv
module hsx_ctrl
  import hsx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       srcRstN,
  input  logic       sendStrobe,
  output logic       srcBusy,
  output logic       reqLine,
  output logic       ackSync,
  input  logic       dstClk,
  input  logic       dstRstN,
  output hsxStrobe_t strobes
);

  srcState_t srcState, srcStateNxt;
  logic      reqNxt;
  logic      reqSync;
  logic      ackLine;

  // ---------------- source domain ----------------
  hsx_sync #(.STAGES(SYNC_STAGES)) ackSync_i (
    .clk (srcClk),
    .rstN(srcRstN),
    .din (ackLine),
    .dout(ackSync)
  );

  always_comb begin
    srcStateNxt     = srcState;
    reqNxt          = reqLine;
    strobes.srcLoad = 1'b0;
    unique case (srcState)
      SRC_IDLE: begin
        if (sendStrobe) begin
          strobes.srcLoad = 1'b1;
          reqNxt          = 1'b1;
          srcStateNxt     = SRC_WAIT_ACK;
        end
      end
      SRC_WAIT_ACK: begin
        if (ackSync) begin
          reqNxt      = 1'b0;
          srcStateNxt = SRC_WAIT_ACK_LOW;
        end
      end
      SRC_WAIT_ACK_LOW: begin
        if (!ackSync) srcStateNxt = SRC_IDLE;
      end
      default: begin
        reqNxt      = 1'b0;
        srcStateNxt = SRC_IDLE;
      end
    endcase
  end

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      srcState <= SRC_IDLE;
      reqLine  <= 1'b0;
    end else begin
      srcState <= srcStateNxt;
      reqLine  <= reqNxt;
    end
  end

  assign srcBusy = (srcState != SRC_IDLE);

  // ---------------- destination domain ----------------
  hsx_sync #(.STAGES(SYNC_STAGES)) reqSync_i (
    .clk (dstClk),
    .rstN(dstRstN),
    .din (reqLine),
    .dout(reqSync)
  );

  // ack follows the synchronized request one cycle later; the gap
  // between the two marks the first cycle req is seen high.
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) ackLine <= 1'b0;
    else          ackLine <= reqSync;
  end

  assign strobes.dstCapture = reqSync & ~ackLine;

endmodule

// File: rtl/hsx_datapath.sv
module hsx_datapath
  import hsx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  hsxStrobe_t        strobes,
  input  logic [DATA_W-1:0] sendData,
  output logic [DATA_W-1:0] heldWord,
  output logic [DATA_W-1:0] dstData,
  output logic              dstValid
);

  // Source-owned copy; stable for the whole handshake.
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)             heldWord <= '0;
    else if (strobes.srcLoad) heldWord <= sendData;
  end

  // Destination capture: heldWord is quiet by protocol when sampled.
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      dstData  <= '0;
      dstValid <= 1'b0;
    end else begin
      dstValid <= strobes.dstCapture;
      if (strobes.dstCapture) dstData <= heldWord;
    end
  end

endmodule

// File: rtl/handshake_xfer.sv
module handshake_xfer
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              sendStrobe,
  input  logic [DATA_W-1:0] sendData,
  output logic              srcBusy,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [DATA_W-1:0] dstData,
  output logic              dstValid
);

  hsxStrobe_t        strobes;
  logic              reqLine;
  logic              ackSync;
  logic [DATA_W-1:0] heldWord;

  hsx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .srcClk    (srcClk),
    .srcRstN   (srcRstN),
    .sendStrobe(sendStrobe),
    .srcBusy   (srcBusy),
    .reqLine   (reqLine),
    .ackSync   (ackSync),
    .dstClk    (dstClk),
    .dstRstN   (dstRstN),
    .strobes   (strobes)
  );

  hsx_datapath #(.DATA_W(DATA_W)) dp_i (
    .srcClk  (srcClk),
    .srcRstN (srcRstN),
    .dstClk  (dstClk),
    .dstRstN (dstRstN),
    .strobes (strobes),
    .sendData(sendData),
    .heldWord(heldWord),
    .dstData (dstData),
    .dstValid(dstValid)
  );

endmodule

// File: rtl/hsx_checker.sv
module hsx_checker #(
  parameter int DATA_W = 16
) (
  input logic              srcClk,
  input logic              srcRstN,
  input logic              sendStrobe,
  input logic              srcBusy,
  input logic              reqLine,
  input logic              ackSync,
  input logic [DATA_W-1:0] heldWord,
  input logic              dstClk,
  input logic              dstRstN,
  input logic [DATA_W-1:0] dstData,
  input logic              dstValid
);

  p_busy_from_send_r2: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $rose(srcBusy) |-> $past(sendStrobe));

  p_held_stable_r3: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (srcBusy && $past(srcBusy)) |-> $stable(heldWord));

  p_valid_single_r5: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstValid |=> !dstValid);

  p_data_with_valid_r5: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !$stable(dstData) |-> dstValid);

  p_req_drop_after_ack_r6: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $fell(reqLine) |-> $past(ackSync));

  p_idle_after_ack_low_r6: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $fell(srcBusy) |-> !ackSync);

endmodule

bind handshake_xfer hsx_checker #(.DATA_W(DATA_W)) chk_i (
  .srcClk    (srcClk),
  .srcRstN   (srcRstN),
  .sendStrobe(sendStrobe),
  .srcBusy   (srcBusy),
  .reqLine   (reqLine),
  .ackSync   (ackSync),
  .heldWord  (heldWord),
  .dstClk    (dstClk),
  .dstRstN   (dstRstN),
  .dstData   (dstData),
  .dstValid  (dstValid)
);

// File: tb/handshake_xfer_tb_top.sv
`timescale 1ns/1ps
module handshake_xfer_tb_top;

  localparam int DW = 16;

  logic          srcClk = 1'b0;
  logic          dstClk = 1'b0;
  logic          srcRstN = 1'b0;
  logic          dstRstN = 1'b0;
  logic          sendStrobe = 1'b0;
  logic [DW-1:0] sendData = '0;
  logic          srcBusy;
  logic [DW-1:0] dstData;
  logic          dstValid;

  realtime dstHalf = 4.0;

  always #4 srcClk = ~srcClk;          // 125 MHz
  always #(dstHalf) dstClk = ~dstClk;

  handshake_xfer #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .srcClk    (srcClk),
    .srcRstN   (srcRstN),
    .sendStrobe(sendStrobe),
    .sendData  (sendData),
    .srcBusy   (srcBusy),
    .dstClk    (dstClk),
    .dstRstN   (dstRstN),
    .dstData   (dstData),
    .dstValid  (dstValid)
  );

  int            checks = 0;
  int            fails = 0;
  int            accepted = 0;
  int            delivered = 0;
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] lastOut = '0;
  logic          prevValid = 1'b0;
  logic          prevBusy = 1'b0;
  logic          expectBusy = 1'b0;
  logic          monOn = 1'b0;
  logic          done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Destination-side reference: compare on every dstClk cycle
  always @(negedge dstClk) begin
    if (monOn) begin
      if (dstValid) begin
        check(!prevValid, "R5", "valid longer than one cycle", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "delivery with no accepted word", dstData, 0);
        end else begin
          check(dstData == expQ[0], "R4", "delivered word", dstData, expQ[0]);
          void'(expQ.pop_front());
        end
        delivered++;
        lastOut = dstData;
      end else begin
        check(dstData == lastOut, "R5", "output held without valid", dstData, lastOut);
      end
      prevValid = dstValid;
    end
  end

  // Source-side reference step: one srcClk cycle
  task automatic step(input bit wantSend);
    logic b;
    @(negedge srcClk);
    b = srcBusy;
    if (expectBusy)
      check(b == 1'b1, "R2", "busy after accepted send", b, 1);
    else if (!prevBusy)
      check(b == 1'b0, "R2", "busy without accepted send", b, 0);
    if (prevBusy && !b)
      check(delivered == accepted, "R6", "deliveries when busy fell", delivered, accepted);
    sendStrobe = wantSend;
    sendData   = DW'($urandom);
    expectBusy = wantSend && !b;
    if (expectBusy) begin
      expQ.push_back(sendData);
      accepted++;
    end
    prevBusy = b;
  endtask

  initial begin
    repeat (150000) @(posedge srcClk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    realtime halves[4] = '{4.0, 1.5, 10.5, 6.85};
    // R1: reset state
    repeat (4) @(negedge srcClk);
    check(srcBusy == 1'b0, "R1", "busy in reset", srcBusy, 0);
    check(dstValid == 1'b0, "R1", "valid in reset", dstValid, 0);
    check(dstData == '0, "R1", "data in reset", dstData, 0);
    @(negedge dstClk); dstRstN = 1'b1;
    @(negedge srcClk); srcRstN = 1'b1;
    monOn = 1'b1;

    for (int ph = 0; ph < 4; ph++) begin
      int startAcc = accepted;
      dstHalf = halves[ph];
      for (int i = 0; i < 400; i++) begin
        bit hold = ((i / 50) % 2) == 1;   // stretches of continuous attempts
        step(hold ? 1'b1 : ($urandom_range(0, 2) == 0));
      end
      for (int i = 0; i < 2000; i++) begin
        step(1'b0);
        if (!srcBusy && expQ.size() == 0) break;
      end
      check(accepted > startAcc, "R2", "words accepted in phase", accepted - startAcc, 1);
      check(expQ.size() == 0, "R4", "words left undelivered", expQ.size(), 0);
    end

    repeat (20) step(1'b0);
    check(accepted == delivered, "R4", "total delivered", delivered, accepted);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule